// File: doc/BRIEF.md
# Two-Stage Lane-Routed Vector Shuffle

This unit reorders a wide vector in two multiplexer stages. The vector is divided into equal lanes, each holding a fixed number of elements. The first stage fills every lane of an intermediate vector with a copy of any input lane. The second stage then picks, inside each lane of that intermediate vector, which element goes to each position. One compact pattern drives the second stage, and that pattern is shared by every lane.

The caller presents an input vector, a lane-routing control word and an element-pattern control word, all qualified by a valid strobe. The reordered vector appears on a registered output one clock later, together with its own valid flag. Both control words accept repeated selects. This lets the unit broadcast a lane or an element as well as permute them.

Top module: `vshuf_top`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_vec` is all zeros.
- R2: `out_valid` equals the `in_valid` value from the previous clock edge, so the latency is exactly one cycle.
- R3: When `in_valid` is 1, intermediate lane k is the input lane numbered by `lane_sel[2k+1:2k]`. Lane 0 occupies `in_vec[127:0]`.
- R4: Output element j of every lane is the element numbered by `elem_sel[2j+1:2j]` inside the same intermediate lane. Element 0 is the lowest 32 bits of a lane. No element moves across a lane boundary.
- R5: Any lane select may repeat, including all four the same, and any element select may repeat. Repeats broadcast the chosen lane or element.
- R6: With `lane_sel = 8'hE4` and `elem_sel = 8'hE4`, `out_vec` equals `in_vec`.
- R7: When `in_valid` is 0, `out_vec` keeps its previous value whatever the data and control inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input qualifier |
| in_vec | input | 512 | Source vector, 16 elements of 32 bits |
| lane_sel | input | 8 | Lane routing, 2 bits per intermediate lane |
| elem_sel | input | 8 | In-lane element pattern shared by all lanes |
| out_valid | output | 1 | Output qualifier |
| out_vec | output | 512 | Reordered vector |

## Verification
The input vector labels every element with a unique value that carries both its lane and element index. Any misrouted element therefore shows up as a wrong label. All 256 lane patterns are swept against a fixed set of element patterns, and all 256 element patterns are swept against fixed lane patterns. This separates stage-one faults from stage-two faults and covers identity, full reversal and all-duplicate selects. Random vectors and random controls then exercise the data paths with arbitrary bits. Cycles with `in_valid` low and changing inputs confirm that the output is held.

// File: rtl/vshuf_pkg.sv
package vshuf_pkg;
    parameter int ELEM_W   = 32;
    parameter int ELEMS    = 4;
    parameter int LANES    = 4;
    localparam int LANE_W  = ELEM_W * ELEMS;
    localparam int VEC_W   = LANE_W * LANES;
    localparam int LSEL_W  = $clog2(LANES);
    localparam int ESEL_W  = $clog2(ELEMS);
    localparam int LCTL_W  = LSEL_W * LANES;
    localparam int ECTL_W  = ESEL_W * ELEMS;

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] vec;
    } out_state_t;
endpackage

// File: rtl/vshuf_lane_route.sv
module vshuf_lane_route
    import vshuf_pkg::*;
(
    input  logic [VEC_W-1:0]  src_vec,
    input  logic [LCTL_W-1:0] route_ctl,
    output logic [VEC_W-1:0]  mid_vec
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LSEL_W-1:0] pick;
        assign pick = route_ctl[k*LSEL_W +: LSEL_W];
        always_comb begin
            mid_vec[k*LANE_W +: LANE_W] = '0;
            for (int s = 0; s < LANES; s++) begin
                if (pick == LSEL_W'(s))
                    mid_vec[k*LANE_W +: LANE_W] = src_vec[s*LANE_W +: LANE_W];
            end
        end
    end
endmodule

// File: rtl/vshuf_elem_pick.sv
module vshuf_elem_pick
    import vshuf_pkg::*;
(
    input  logic [VEC_W-1:0]  mid_vec,
    input  logic [ECTL_W-1:0] pat_ctl,
    output logic [VEC_W-1:0]  res_vec
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W-1:0] lane_in;
        assign lane_in = mid_vec[k*LANE_W +: LANE_W];
        for (genvar j = 0; j < ELEMS; j++) begin : g_elem
            logic [ESEL_W-1:0] pick;
            assign pick = pat_ctl[j*ESEL_W +: ESEL_W];
            always_comb begin
                res_vec[k*LANE_W + j*ELEM_W +: ELEM_W] = '0;
                for (int s = 0; s < ELEMS; s++) begin
                    if (pick == ESEL_W'(s))
                        res_vec[k*LANE_W + j*ELEM_W +: ELEM_W] = lane_in[s*ELEM_W +: ELEM_W];
                end
            end
        end
    end
endmodule

// File: rtl/vshuf_top.sv
module vshuf_top
    import vshuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [VEC_W-1:0]  in_vec,
    input  logic [LCTL_W-1:0] lane_sel,
    input  logic [ECTL_W-1:0] elem_sel,
    output logic              out_valid,
    output logic [VEC_W-1:0]  out_vec
);
    logic [VEC_W-1:0] mid_vec;
    logic [VEC_W-1:0] res_vec;
    out_state_t       st_d, st_q;

    vshuf_lane_route u_route (
        .src_vec   (in_vec),
        .route_ctl (lane_sel),
        .mid_vec   (mid_vec)
    );

    vshuf_elem_pick u_pick (
        .mid_vec (mid_vec),
        .pat_ctl (elem_sel),
        .res_vec (res_vec)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) st_d.vec = res_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_vec   = st_q.vec;

    // R2
    valid_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_valid)));
    // R7
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_vec));
    // R6
    identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_sel == 8'hE4 && elem_sel == 8'hE4) |=> (out_vec == $past(in_vec)));
    // R5
    bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_sel == 8'h00 && elem_sel == 8'h00) |=>
        (out_vec == {16{$past(in_vec[31:0])}}));
    // R4
    lane_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_sel == 8'hE4) |=>
        (out_vec[127:0] == {$past(in_vec[32*elem_sel[7:6] +: 32]), $past(in_vec[32*elem_sel[5:4] +: 32]),
                            $past(in_vec[32*elem_sel[3:2] +: 32]), $past(in_vec[32*elem_sel[1:0] +: 32])}));
endmodule

// File: tb/tb_vshuf_top.sv
module tb_vshuf_top;
    logic         clk = 0;
    logic         rst_n = 0;
    logic         in_valid = 0;
    logic [511:0] in_vec = '0;
    logic [7:0]   lane_sel = '0;
    logic [7:0]   elem_sel = '0;
    logic         out_valid;
    logic [511:0] out_vec;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    vshuf_top dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
                   .lane_sel(lane_sel), .elem_sel(elem_sel),
                   .out_valid(out_valid), .out_vec(out_vec));

    function automatic logic [511:0] model(logic [511:0] v, logic [7:0] ls, logic [7:0] es);
        logic [511:0] r;
        for (int k = 0; k < 4; k++)
            for (int j = 0; j < 4; j++) begin
                int sl = (ls >> (2*k)) & 3;
                int se = (es >> (2*j)) & 3;
                r[(k*4+j)*32 +: 32] = v[(sl*4+se)*32 +: 32];
            end
        return r;
    endfunction

    function automatic logic [511:0] labelled(logic [15:0] tag);
        logic [511:0] r;
        for (int i = 0; i < 16; i++) r[i*32 +: 32] = {tag, 8'hA0 + 8'(i / 4), 8'(i % 4)};
        return r;
    endfunction

    task automatic chk(string req, logic [511:0] act, logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic chk1(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0b exp=%0b", req, act, exp);
        end
    endtask

    task automatic run(string req, logic [511:0] v, logic [7:0] ls, logic [7:0] es);
        @(negedge clk);
        in_valid = 1; in_vec = v; lane_sel = ls; elem_sel = es;
        @(negedge clk);
        chk1(req, out_valid, 1'b1);
        chk(req, out_vec, model(v, ls, es));
    endtask

    initial begin
        logic [511:0] held;
        logic [511:0] rv;
        #5;
        chk1("R1", out_valid, 1'b0);
        chk("R1", out_vec, '0);
        @(negedge clk); rst_n = 1;
        // R6 identity
        run("R6", labelled(16'h1234), 8'hE4, 8'hE4);
        chk("R6", out_vec, labelled(16'h1234));
        // R3 all lane patterns, R4 fixed element patterns
        for (int l = 0; l < 256; l++) begin
            run("R3", labelled(16'(l)), 8'(l), 8'hE4);
            run("R3", labelled(16'(l)), 8'(l), 8'h1B);
        end
        // R4 all element patterns
        for (int e = 0; e < 256; e++) begin
            run("R4", labelled(16'(e)), 8'hE4, 8'(e));
            run("R4", labelled(16'(e)), 8'h1B, 8'(e));
        end
        // R5 all-duplicate selects
        for (int d = 0; d < 4; d++)
            for (int f = 0; f < 4; f++)
                run("R5", labelled(16'hD00D), {4{2'(d)}}, {4{2'(f)}});
        // R3 full reversal
        run("R3", labelled(16'hBEEF), 8'h1B, 8'h1B);
        // random data
        for (int n = 0; n < 300; n++) begin
            for (int w = 0; w < 16; w++) rv[w*32 +: 32] = $urandom;
            run("R4", rv, 8'($urandom), 8'($urandom));
        end
        // R7 hold when idle, R2 valid lag
        held = out_vec;
        @(negedge clk);
        in_valid = 0; in_vec = ~in_vec; lane_sel = 8'h55; elem_sel = 8'hAA;
        @(negedge clk);
        chk1("R2", out_valid, 1'b0);
        chk("R7", out_vec, held);
        in_vec = labelled(16'h7777); lane_sel = 8'h1B;
        @(negedge clk);
        chk("R7", out_vec, held);
        run("R2", labelled(16'h4242), 8'h93, 8'h6C);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin repeat (20000) @(posedge clk); errors++; checks++;
                  $display("FAIL watchdog act=timeout exp=done"); end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule